// File: doc/BRIEF.md
# DDR2 Power-Up Initialisation Sequencer

This block takes freshly powered DDR2 devices from their first command to a programmed state. A single-cycle start pulse sets it running. It emits a fixed list of DRAM commands as packed 32-bit command words. Between certain commands it holds off for a required settling time. The whole list runs for rank 0. If the second rank was enabled when the start pulse arrived, the list then runs again with the rank-select bit set. A one-cycle completion pulse follows the last word.

The command words leave on a valid/ready stream port, and the downstream consumer turns each word into a real DRAM command:
- A word is offered with `cmd_valid_o` high and stays unchanged until `cmd_ready_i` is seen high on a rising edge. That edge is the handshake.
- The consumer may hold `cmd_ready_i` low for any number of cycles. The sequencer simply stalls.
- The sequencer never withdraws a word it has offered.
- A settling wait starts counting on the cycle after the handshake of the command before it. During the wait, `cmd_valid_o` is low.

The two wait lengths are set at build time:
- `CLK_PERIOD_NS` and `TPWR_NS` give the post-NOP wait, rounded up to whole cycles.
- `MRD_WAIT_CLKS` gives the wait after the DLL-reset mode write.

Top module: `ddr2_init_seq`

## Requirements
- R1: Every offered word has bits 31:22 at zero, the rank select in bit 21, mode-register address bits 14:0 in bits 20:6, the mode-register select in bits 5:3 (MR=000, EMR1=001, EMR2=010, EMR3=011) and the command in bits 2:0 (mode register set=000, refresh=001, precharge=010, NOP=111).
- R2: For each rank the words come in this order: NOP, precharge all, EMR2=0, EMR3=0, EMR1=0x404, MR=0x362, precharge all, refresh, refresh, MR=0x262, EMR1=0x784, EMR1=0x404. At rank 0 these are 0x00000007, 0x00010002, 0x00000010, 0x00000018, 0x00010108, 0x0000D880, 0x00010002, 0x00000001, 0x00000001, 0x00009880, 0x0001E108, 0x00010108.
- R3: A precharge-all word carries address bit 10 set, which is word bit 16.
- R4: After the NOP handshake, `cmd_valid_o` stays low for exactly ceil(TPWR_NS/CLK_PERIOD_NS) cycles, which is 20 at the defaults, before the precharge is offered.
- R5: After the MR=0x262 handshake, `cmd_valid_o` stays low for exactly `MRD_WAIT_CLKS` cycles, which is 200 at the defaults, before the EMR1=0x784 word is offered.
- R6: When `rank1_en_i` was high at the start pulse, the twelve words repeat for rank 1 with bit 21 set (each rank-0 value plus 0x00200000). When it was low, exactly twelve words are issued and nothing more is offered.
- R7: While a word is offered and not accepted, `cmd_valid_o` stays high and `cmd_word_o` stays unchanged. The sequence advances only on handshakes.
- R8: `done_o` is high for exactly one cycle, on the cycle after the last handshake. `busy_o` is low from that cycle on.
- R9: A start pulse while the sequencer is busy has no effect on the words issued or on their count.
- R10: After reset `busy_o`, `cmd_valid_o` and `done_o` are low. A reset in mid-sequence returns the sequencer to idle with no word offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Start pulse, taken only when idle |
| rank1_en_i | input | 1 | Second rank populated, sampled with the start pulse |
| cmd_valid_o | output | 1 | Command word offered |
| cmd_ready_i | input | 1 | Consumer accepts the offered word |
| cmd_word_o | output | 32 | Packed DRAM init command word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench counts the exact low-valid gap after the NOP and after the DLL-reset MR write. A counter that is off by one, or that starts at the wrong handshake, shows up as a gap of 19 or 201 cycles, or as a gap placed after the wrong word. It stalls `cmd_ready_i` periodically to catch a word that changes or advances without a handshake. It runs both with and without the second rank, to catch a missing rank-select bit or a spurious second pass. It also pokes the start input mid-run and resets mid-run, which a design that restarts on a late start pulse, or leaks words after reset, would fail.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  // command codes (word bits 2:0)
  localparam logic [2:0] CMD_MRS  = 3'b000;
  localparam logic [2:0] CMD_REF  = 3'b001;
  localparam logic [2:0] CMD_PRE  = 3'b010;
  localparam logic [2:0] CMD_NOP  = 3'b111;

  // mode register select codes (word bits 5:3)
  localparam logic [2:0] SEL_MR   = 3'b000;
  localparam logic [2:0] SEL_EMR1 = 3'b001;
  localparam logic [2:0] SEL_EMR2 = 3'b010;
  localparam logic [2:0] SEL_EMR3 = 3'b011;

  localparam int unsigned STEPS = 14;
  localparam int unsigned IDX_W = $clog2(STEPS);

  typedef enum logic [1:0] {
    STEP_CMD,
    STEP_WAIT_PWR,
    STEP_WAIT_MRD
  } step_kind_e;

  typedef struct packed {
    step_kind_e  kind;
    logic [2:0]  cmd;
    logic [2:0]  sel;
    logic [14:0] addr;
  } step_t;

  function automatic logic [31:0] pack_word(input logic rank, input step_t s);
    return {10'd0, rank, s.addr, s.sel, s.cmd};
  endfunction

endpackage

// File: rtl/ddr2_init_step_rom.sv
module ddr2_init_step_rom
  import ddr2_init_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  localparam logic [14:0] A10 = 15'h0400;

  always_comb begin
    step = '{kind: STEP_CMD, cmd: CMD_NOP, sel: SEL_MR, addr: 15'h0};
    unique case (idx)
      IDX_W'(0):  step.cmd  = CMD_NOP;
      IDX_W'(1):  step.kind = STEP_WAIT_PWR;
      IDX_W'(2):  begin step.cmd = CMD_PRE; step.addr = A10; end
      IDX_W'(3):  begin step.cmd = CMD_MRS; step.sel = SEL_EMR2; end
      IDX_W'(4):  begin step.cmd = CMD_MRS; step.sel = SEL_EMR3; end
      IDX_W'(5):  begin step.cmd = CMD_MRS; step.sel = SEL_EMR1; step.addr = 15'h0404; end
      IDX_W'(6):  begin step.cmd = CMD_MRS; step.addr = 15'h0362; end
      IDX_W'(7):  begin step.cmd = CMD_PRE; step.addr = A10; end
      IDX_W'(8):  step.cmd  = CMD_REF;
      IDX_W'(9):  step.cmd  = CMD_REF;
      IDX_W'(10): begin step.cmd = CMD_MRS; step.addr = 15'h0262; end
      IDX_W'(11): step.kind = STEP_WAIT_MRD;
      IDX_W'(12): begin step.cmd = CMD_MRS; step.sel = SEL_EMR1; step.addr = 15'h0784; end
      IDX_W'(13): begin step.cmd = CMD_MRS; step.sel = SEL_EMR1; step.addr = 15'h0404; end
      default:    step.cmd  = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr)        count <= '0;
    else if (count != '1)     count <= count + 1'b1;
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned TPWR_NS       = 400,
  parameter int unsigned MRD_WAIT_CLKS = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_i,
  input  logic        rank1_en_i,
  output logic        cmd_valid_o,
  input  logic        cmd_ready_i,
  output logic [31:0] cmd_word_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam int unsigned PWR_RAW      = (TPWR_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int unsigned NOP_WAIT_CYC = (PWR_RAW < 1) ? 1 : PWR_RAW;
  localparam int unsigned MRD_CYC      = (MRD_WAIT_CLKS < 1) ? 1 : MRD_WAIT_CLKS;
  localparam int unsigned MAX_WAIT     = (NOP_WAIT_CYC > MRD_CYC) ? NOP_WAIT_CYC : MRD_CYC;
  localparam int unsigned WAIT_W       = $clog2(MAX_WAIT + 1);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(STEPS - 1);

  logic             running, rank, r1en_q, done_q;
  logic [IDX_W-1:0] idx;
  step_t            cur;
  logic [WAIT_W-1:0] tcnt;
  logic             wait_hit, adv, is_cmd;

  ddr2_init_step_rom u_rom (.idx(idx), .step(cur));

  ddr2_init_timer #(.W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(adv || !running), .count(tcnt)
  );

  assign is_cmd   = (cur.kind == STEP_CMD);
  assign wait_hit = ((cur.kind == STEP_WAIT_PWR) && (tcnt == WAIT_W'(NOP_WAIT_CYC - 1))) ||
                    ((cur.kind == STEP_WAIT_MRD) && (tcnt == WAIT_W'(MRD_CYC - 1)));
  assign adv      = running && (is_cmd ? cmd_ready_i : wait_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx     <= '0;
      rank    <= 1'b0;
      r1en_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!running) begin
        if (go_i) begin
          running <= 1'b1;
          idx     <= '0;
          rank    <= 1'b0;
          r1en_q  <= rank1_en_i;
        end
      end else if (adv) begin
        if (idx == LAST) begin
          if (!rank && r1en_q) begin
            rank <= 1'b1;
            idx  <= '0;
          end else begin
            running <= 1'b0;
            done_q  <= 1'b1;
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign cmd_valid_o = running && is_cmd;
  assign cmd_word_o  = cmd_valid_o ? pack_word(rank, cur) : 32'h0;
  assign busy_o      = running;
  assign done_o      = done_q;
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int unsigned PWR_GAP = 20,
  parameter int unsigned MRD_GAP = 200
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [31:0] cmd_word_o,
  input logic        busy_o,
  input logic        done_o
);
  logic [15:0] gap;
  logic        after_nop, after_dll;
  logic        hs;

  assign hs = cmd_valid_o && cmd_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap       <= '0;
      after_nop <= 1'b0;
      after_dll <= 1'b0;
    end else if (hs) begin
      gap       <= '0;
      after_nop <= (cmd_word_o[2:0] == 3'b111);
      after_dll <= (cmd_word_o[20:0] == {15'h0262, 3'b000, 3'b000});
    end else if (!cmd_valid_o && gap != 16'hFFFF) begin
      gap <= gap + 1'b1;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_word_o));

  // R1
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cmd_word_o[31:22] == 10'd0);

  // R3
  prea_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_word_o[2:0] == 3'b010 |-> cmd_word_o[16]);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_valid_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R4
  pwr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && after_nop |-> gap >= 16'(PWR_GAP));

  // R5
  mrd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && after_dll |-> gap >= 16'(MRD_GAP));
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
  .PWR_GAP(NOP_WAIT_CYC),
  .MRD_GAP(MRD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
  .cmd_word_o(cmd_word_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_ddr2_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2_init_seq;
  localparam int NOPW = 20;   // 400 ns at 20 ns
  localparam int MRDW = 200;
  localparam logic [31:0] RANK1 = 32'h0020_0000;
  localparam logic [31:0] EXP [12] = '{
    32'h0000_0007, 32'h0001_0002, 32'h0000_0010, 32'h0000_0018,
    32'h0001_0108, 32'h0000_D880, 32'h0001_0002, 32'h0000_0001,
    32'h0000_0001, 32'h0000_9880, 32'h0001_E108, 32'h0001_0108
  };

  logic clk = 1'b0, rst_n = 1'b0, go_i = 1'b0, rank1_en_i = 1'b0, cmd_ready_i = 1'b0;
  logic cmd_valid_o, busy_o, done_o;
  logic [31:0] cmd_word_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ddr2_init_seq dut (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .rank1_en_i(rank1_en_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_word_o(cmd_word_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // runs one full sequence; stall>0 holds ready low every stall-th cycle
  task automatic run_seq(input logic r1en, input int stall, input bit poke_go);
    int total = r1en ? 24 : 12;
    int idx = 0, gap = 0, cyc = 0;
    bit holding = 0;
    logic [31:0] held = '0;
    @(negedge clk);
    go_i = 1'b1; rank1_en_i = r1en;
    @(negedge clk);
    go_i = 1'b0; rank1_en_i = ~r1en;   // later changes must not matter
    while (idx < total && cyc < 20000) begin
      logic rdy;
      go_i = poke_go && (cyc == 30);
      if (holding) begin
        chk(cmd_valid_o === 1'b1, "R7 valid held", {31'd0, cmd_valid_o}, 32'd1);
        chk(cmd_word_o === held, "R7 word held", cmd_word_o, held);
      end
      if (cmd_valid_o) begin
        logic [31:0] exp = EXP[idx % 12] | ((idx >= 12) ? RANK1 : 32'h0);
        if (!holding) begin
          chk(cmd_word_o === exp, (idx >= 12) ? "R6 rank1 word" : "R2 rank0 word", cmd_word_o, exp);
          chk(cmd_word_o[31:22] == 10'd0, "R1 upper zero", cmd_word_o, exp);
          if (cmd_word_o[2:0] == 3'b010)
            chk(cmd_word_o[16] == 1'b1, "R3 precharge A10", cmd_word_o, exp);
          if (idx % 12 == 1) chk(gap == NOPW, "R4 nop wait", gap, NOPW);
          else if (idx % 12 == 10) chk(gap == MRDW, "R5 mrd wait", gap, MRDW);
          else chk(gap == 0, "R2 no gap", gap, 0);
        end
        rdy = (stall == 0) || ((cyc % stall) != 0);
        if (rdy) begin idx++; gap = 0; holding = 0; end
        else begin holding = 1; held = cmd_word_o; end
      end else begin
        rdy = 1'b1;
        gap++;
        holding = 0;
      end
      cmd_ready_i = rdy;
      cyc++;
      @(negedge clk);
    end
    go_i = 1'b0;
    chk(cyc < 20000, "R7 run finished", cyc, 20000);
    chk(done_o === 1'b1, "R8 done pulse", {31'd0, done_o}, 32'd1);
    chk(busy_o === 1'b0, "R8 busy low", {31'd0, busy_o}, 32'd0);
    cmd_ready_i = 1'b1;
    @(negedge clk);
    chk(done_o === 1'b0, "R8 done one cycle", {31'd0, done_o}, 32'd0);
    for (int k = 0; k < 5; k++) begin
      chk(cmd_valid_o === 1'b0, poke_go ? "R9 no restart" : "R6 no extra word", {31'd0, cmd_valid_o}, 32'd0);
      @(negedge clk);
    end
    cmd_ready_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy_o === 1'b0, "R10 busy reset", {31'd0, busy_o}, 32'd0);
    chk(cmd_valid_o === 1'b0, "R10 valid reset", {31'd0, cmd_valid_o}, 32'd0);
    chk(done_o === 1'b0, "R10 done reset", {31'd0, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_seq(1'b0, 0, 1'b0);   // single rank, no stall
    run_seq(1'b1, 0, 1'b0);   // two ranks
    run_seq(1'b1, 3, 1'b0);   // two ranks, back-pressure
    run_seq(1'b0, 2, 1'b1);   // R9 go poked while busy

    // R10 reset mid-sequence
    @(negedge clk);
    go_i = 1'b1; rank1_en_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0; cmd_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(cmd_valid_o === 1'b0 && busy_o === 1'b0, "R10 idle after reset",
          {30'd0, busy_o, cmd_valid_o}, 32'd0);
      @(negedge clk);
    end
    cmd_ready_i = 1'b0;
    run_seq(1'b0, 0, 1'b0);   // fresh start after reset
    finish_run();
  end
endmodule